// File: doc/BRIEF.md
# Paged Boot Loader

This block loads an on-chip program memory, 24 bits wide, from an external memory that is 8 bits wide. The external space holds 16K bytes in eight pages of 2K bytes. The loader runs on its own after reset. Software can also start it from a control write. For every byte it drives the boot select and read strobes and places the byte address on the address pins. It holds each read for a programmable number of wait states, then samples the byte from the upper half of the low data word. It packs three consecutive bytes into a program word, most significant byte first, and writes the word into the internal memory.

The page number is split across pins during reads. Its low bit travels on address bit 13 and its two high bits on two upper data-bus pins (`page_hi_o`). An external master may ask for the bus while a boot is running. The loader finishes the byte it is reading, grants the bus, and continues with the next byte once the request drops. After the last of the 512 words is written, a one-cycle done pulse is raised and the core is released to execute from program address 0.

Top module: `boot_loader`

## Requirements
- R1: After reset, when `map_sel_i` is 0 and no bus request is pending, a boot from page 0 with 3 wait states starts without any software action. When `map_sel_i` is 1, `run_o` goes high on the first clock after reset and no byte is read. While reset is held, `rd_o`, `run_o`, `done_o` and `bus_grant_o` are 0.
- R2: During a read, `addr_o[10:0]` carries the byte offset inside the page, `addr_o[13]` carries page bit 0, `addr_o[12:11]` are 0, and `page_hi_o` carries page bits 2:1. Outside reads, `addr_o` and `page_hi_o` are 0.
- R3: Each byte read keeps `boot_sel_o` and `rd_o` high for exactly ws+1 cycles, where ws is the current wait-state setting (0 to 7). The byte is sampled at the end of the last of those cycles.
- R4: Word n (n = 0 to 511) is written to `pm_addr_o` = n with `pm_wdata_o` = {byte 3n, byte 3n+1, byte 3n+2}. The offsets run from 0 to 1535 in order, and `pm_we_o` is never high on two cycles in a row.
- R5: A bus request present when reset ends holds off the automatic boot. `bus_grant_o` stays high with no reads until the request drops, and the boot from page 0 then runs in full.
- R6: A bus request during a boot is granted only at a byte boundary, after the byte in progress has been sampled. No read is made while `bus_grant_o` is high, and loading resumes with the next byte, so no byte is lost or repeated.
- R7: `done_o` is high for exactly one cycle, together with the write of word 511. From that same cycle on, `run_o` stays high and the loader makes no reads.
- R8: A write with `cfg_we_i` high while running stores the page (`cfg_page_i`) and the wait states (`cfg_ws_i`). If `cfg_force_i` is also high, a full boot of the chosen page starts with those wait states. Without it, no boot starts.
- R9: Control writes made while a boot is in progress are ignored. The running boot keeps its page and timing, and no second boot follows.
- R10: While running, the loader ignores `bus_req_i` and keeps `bus_grant_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| map_sel_i | input | 1 | 1 skips the automatic boot after reset |
| bus_req_i | input | 1 | External bus request |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_force_i | input | 1 | Force-boot bit of the control write |
| cfg_page_i | input | 3 | Page field of the control write |
| cfg_ws_i | input | 3 | Wait-state field of the control write |
| byte_i | input | 8 | Boot byte from data pins 15:8 |
| boot_sel_o | output | 1 | Boot memory select |
| rd_o | output | 1 | Read strobe |
| addr_o | output | 14 | Byte address, page bit 0 on bit 13 |
| page_hi_o | output | 2 | Page bits 2:1 for the upper data pins |
| bus_grant_o | output | 1 | Bus granted to the external master |
| pm_we_o | output | 1 | Program memory write enable |
| pm_addr_o | output | 9 | Program memory word address |
| pm_wdata_o | output | 24 | Packed program word |
| done_o | output | 1 | One-cycle pulse with the last word write |
| run_o | output | 1 | Core released to run from address 0 |

## Verification
The bench models the boot memory as a function of page and offset. The high offset bits feed into every byte, so a packer that swaps byte order or drops a byte fails the word compare on many addresses. It measures strobe cycles per boot for wait settings from 0 to 7. A wait counter that is off by one shows up as a total other than 1536 × (ws+1). Bus requests are raised at arbitrary points during a boot and also across reset. A loader that grants in the middle of a byte is caught by a strobe count at the grant that is not a multiple of ws+1, and one that loses or repeats a byte is caught by the data compare. Control writes made during a boot, plain writes without the force bit, and requests while running must leave the reads and writes unchanged. A loader that restarts on a write or grants outside a boot is caught there.

// File: rtl/boot_pkg.sv
package boot_pkg;
  localparam int BYTE_W = 8;
  localparam int BPW    = 3;
  localparam int WORD_W = BYTE_W * BPW;

  typedef enum logic [1:0] {
    ST_INIT,
    ST_READ,
    ST_HOLD,
    ST_RUN
  } boot_st_e;
endpackage

// File: rtl/boot_wait.sv
module boot_wait #(
  parameter int WS_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [WS_W-1:0] ws_i,
  input  logic            active_i,
  output logic            last_o
);
  logic [WS_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (load_i)                    cnt_q <= ws_i;
    else if (active_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = active_i && (cnt_q == '0);
endmodule

// File: rtl/boot_pack.sv
module boot_pack
  import boot_pkg::*;
#(
  parameter int PM_DEPTH = 512,
  localparam int PM_AW   = $clog2(PM_DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              cap_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              pm_we_o,
  output logic [PM_AW-1:0]  pm_addr_o,
  output logic [WORD_W-1:0] pm_wdata_o,
  output logic              done_o
);
  localparam int HOLD_W = WORD_W - BYTE_W;
  localparam int SLOT_W = $clog2(BPW);

  logic [SLOT_W-1:0] slot_q;
  logic [HOLD_W-1:0] hold_q;
  logic [PM_AW-1:0]  word_q;
  logic              we_q, done_q;
  logic [PM_AW-1:0]  addr_q;
  logic [WORD_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '0;
      hold_q <= '0;
      word_q <= '0;
      we_q   <= 1'b0;
      done_q <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      we_q   <= 1'b0;
      done_q <= 1'b0;
      if (start_i) begin
        slot_q <= '0;
        word_q <= '0;
      end else if (cap_i) begin
        if (slot_q == SLOT_W'(BPW - 1)) begin
          // last byte of the word: emit it
          data_q <= {hold_q, byte_i};
          addr_q <= word_q;
          we_q   <= 1'b1;
          done_q <= (word_q == PM_AW'(PM_DEPTH - 1));
          word_q <= word_q + 1'b1;
          slot_q <= '0;
        end else begin
          hold_q <= {hold_q[HOLD_W-BYTE_W-1:0], byte_i};
          slot_q <= slot_q + 1'b1;
        end
      end
    end
  end

  assign pm_we_o    = we_q;
  assign pm_addr_o  = addr_q;
  assign pm_wdata_o = data_q;
  assign done_o     = done_q;
endmodule

// File: rtl/boot_seq.sv
module boot_seq
  import boot_pkg::*;
#(
  parameter int PAGE_W = 3,
  parameter int OFS_W  = 11,
  parameter int ADDR_W = 14,
  parameter int WS_W   = 3,
  parameter int WS_RST = 3,
  parameter int BYTES  = 1536
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              map_sel_i,
  input  logic              bus_req_i,
  input  logic              cfg_we_i,
  input  logic              cfg_force_i,
  input  logic [PAGE_W-1:0] cfg_page_i,
  input  logic [WS_W-1:0]   cfg_ws_i,
  input  logic              wait_last_i,
  output logic              wait_load_o,
  output logic [WS_W-1:0]   ws_o,
  output logic              cap_o,
  output logic              start_o,
  output logic              rd_o,
  output logic              boot_sel_o,
  output logic              bus_grant_o,
  output logic              run_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [PAGE_W-2:0] page_hi_o
);
  localparam int GAP_W = ADDR_W - OFS_W - 1;

  boot_st_e          state_q, state_d;
  logic [OFS_W-1:0]  ofs_q;
  logic [PAGE_W-1:0] page_q;
  logic [WS_W-1:0]   ws_q;
  logic              reading, cfg_take, last_byte;

  assign reading   = (state_q == ST_READ);
  assign cap_o     = reading && wait_last_i;
  assign last_byte = (ofs_q == OFS_W'(BYTES - 1));
  assign cfg_take  = (state_q == ST_RUN) && cfg_we_i;
  // a forcing write loads the counter with the value being written
  assign ws_o      = cfg_take ? cfg_ws_i : ws_q;

  always_comb begin
    state_d     = state_q;
    wait_load_o = 1'b0;
    start_o     = 1'b0;
    unique case (state_q)
      ST_INIT: begin
        if (map_sel_i) state_d = ST_RUN;
        else begin
          start_o = 1'b1;
          if (bus_req_i) state_d = ST_HOLD;
          else begin
            state_d     = ST_READ;
            wait_load_o = 1'b1;
          end
        end
      end
      ST_READ: begin
        if (cap_o) begin
          if (last_byte)      state_d = ST_RUN;
          else if (bus_req_i) state_d = ST_HOLD;
          else                wait_load_o = 1'b1;
        end
      end
      ST_HOLD: begin
        if (!bus_req_i) begin
          state_d     = ST_READ;
          wait_load_o = 1'b1;
        end
      end
      ST_RUN: begin
        if (cfg_take && cfg_force_i) begin
          state_d     = ST_READ;
          wait_load_o = 1'b1;
          start_o     = 1'b1;
        end
      end
      default: state_d = ST_INIT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_INIT;
      ofs_q   <= '0;
      page_q  <= '0;
      ws_q    <= WS_W'(WS_RST);
    end else begin
      state_q <= state_d;
      if (start_o)    ofs_q <= '0;
      else if (cap_o) ofs_q <= ofs_q + 1'b1;
      if (cfg_take) begin
        page_q <= cfg_page_i;
        ws_q   <= cfg_ws_i;
      end
    end
  end

  assign rd_o        = reading;
  assign boot_sel_o  = reading;
  assign bus_grant_o = (state_q == ST_HOLD);
  assign run_o       = (state_q == ST_RUN);
  assign addr_o      = reading ? {page_q[0], {GAP_W{1'b0}}, ofs_q} : '0;
  assign page_hi_o   = reading ? page_q[PAGE_W-1:1] : '0;
endmodule

// File: rtl/boot_loader.sv
module boot_loader
  import boot_pkg::*;
#(
  parameter int PM_DEPTH = 512,
  parameter int PAGE_W   = 3,
  parameter int OFS_W    = 11,
  parameter int ADDR_W   = 14,
  parameter int WS_W     = 3,
  parameter int WS_RST   = 3,
  localparam int PM_AW   = $clog2(PM_DEPTH),
  localparam int BYTES   = PM_DEPTH * BPW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              map_sel_i,
  input  logic              bus_req_i,
  input  logic              cfg_we_i,
  input  logic              cfg_force_i,
  input  logic [PAGE_W-1:0] cfg_page_i,
  input  logic [WS_W-1:0]   cfg_ws_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              boot_sel_o,
  output logic              rd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [PAGE_W-2:0] page_hi_o,
  output logic              bus_grant_o,
  output logic              pm_we_o,
  output logic [PM_AW-1:0]  pm_addr_o,
  output logic [WORD_W-1:0] pm_wdata_o,
  output logic              done_o,
  output logic              run_o
);
  logic            wait_load, wait_last, cap, start;
  logic [WS_W-1:0] ws;

  boot_seq #(
    .PAGE_W(PAGE_W), .OFS_W(OFS_W), .ADDR_W(ADDR_W),
    .WS_W(WS_W), .WS_RST(WS_RST), .BYTES(BYTES)
  ) u_seq (
    .clk_i, .rst_ni, .map_sel_i, .bus_req_i,
    .cfg_we_i, .cfg_force_i, .cfg_page_i, .cfg_ws_i,
    .wait_last_i(wait_last),
    .wait_load_o(wait_load),
    .ws_o(ws),
    .cap_o(cap),
    .start_o(start),
    .rd_o, .boot_sel_o, .bus_grant_o, .run_o, .addr_o, .page_hi_o
  );

  boot_wait #(.WS_W(WS_W)) u_wait (
    .clk_i, .rst_ni,
    .load_i(wait_load),
    .ws_i(ws),
    .active_i(rd_o),
    .last_o(wait_last)
  );

  boot_pack #(.PM_DEPTH(PM_DEPTH)) u_pack (
    .clk_i, .rst_ni,
    .start_i(start),
    .cap_i(cap),
    .byte_i,
    .pm_we_o, .pm_addr_o, .pm_wdata_o, .done_o
  );
endmodule

// File: rtl/boot_loader_chk.sv
module boot_loader_chk #(
  parameter int PM_DEPTH = 512,
  parameter int OFS_W    = 11,
  parameter int ADDR_W   = 14,
  parameter int PAGE_W   = 3,
  localparam int PM_AW   = $clog2(PM_DEPTH)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_o,
  input logic              boot_sel_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic [PAGE_W-2:0] page_hi_o,
  input logic              bus_grant_o,
  input logic              pm_we_o,
  input logic [PM_AW-1:0]  pm_addr_o,
  input logic              done_o,
  input logic              run_o
);
  a_r6_grant_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_grant_o |-> (!rd_o && !boot_sel_o));

  a_r10_run_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_o |-> (!rd_o && !bus_grant_o));

  a_r7_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r7_done_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (pm_we_o && run_o && pm_addr_o == PM_AW'(PM_DEPTH - 1)));

  a_r4_we_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pm_we_o |=> !pm_we_o);

  a_r2_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_o && $past(rd_o)) |->
      (addr_o[OFS_W-1:0] == $past(addr_o[OFS_W-1:0]) ||
       addr_o[OFS_W-1:0] == $past(addr_o[OFS_W-1:0]) + 1'b1));

  a_r2_addr_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_o |-> (addr_o == '0 && page_hi_o == '0));
endmodule

bind boot_loader boot_loader_chk #(
  .PM_DEPTH(PM_DEPTH), .OFS_W(OFS_W), .ADDR_W(ADDR_W), .PAGE_W(PAGE_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rd_o(rd_o), .boot_sel_o(boot_sel_o),
  .addr_o(addr_o), .page_hi_o(page_hi_o), .bus_grant_o(bus_grant_o),
  .pm_we_o(pm_we_o), .pm_addr_o(pm_addr_o), .done_o(done_o), .run_o(run_o)
);

// File: tb/tb_boot_loader.sv
module tb_boot_loader;
  localparam int NBYTES = 1536;
  localparam int NWORDS = 512;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        map_sel = 1'b0, bus_req = 1'b0;
  logic        cfg_we = 1'b0, cfg_force = 1'b0;
  logic [2:0]  cfg_page = '0, cfg_ws = '0;
  logic [7:0]  byte_in;
  logic        boot_sel, rd, bus_grant, pm_we, done, run;
  logic [13:0] addr;
  logic [1:0]  page_hi;
  logic [8:0]  pm_addr;
  logic [23:0] pm_wdata;

  always #10 clk = ~clk;

  boot_loader dut (
    .clk_i(clk), .rst_ni(rst_n), .map_sel_i(map_sel), .bus_req_i(bus_req),
    .cfg_we_i(cfg_we), .cfg_force_i(cfg_force), .cfg_page_i(cfg_page),
    .cfg_ws_i(cfg_ws), .byte_i(byte_in), .boot_sel_o(boot_sel), .rd_o(rd),
    .addr_o(addr), .page_hi_o(page_hi), .bus_grant_o(bus_grant),
    .pm_we_o(pm_we), .pm_addr_o(pm_addr), .pm_wdata_o(pm_wdata),
    .done_o(done), .run_o(run)
  );

  function automatic logic [7:0] rom_byte(input logic [2:0] pg, input logic [10:0] ofs);
    return (ofs[7:0] ^ {ofs[10:8], 5'd0}) + 8'(pg * 37) + 8'd5;
  endfunction

  assign byte_in = rd ? rom_byte({page_hi, addr[13]}, addr[10:0]) : 8'h00;

  int tests = 0, fails = 0;
  int rd_cyc, wr_cnt, done_cnt, done_bad, addr_bad, grant_cyc, grant_bad;
  int cur_page = 0, cur_ws = 3;
  bit grant_prev = 1'b0;
  logic [23:0] mem [NWORDS];

  task automatic clear_counts();
    rd_cyc = 0; wr_cnt = 0; done_cnt = 0; done_bad = 0;
    addr_bad = 0; grant_cyc = 0; grant_bad = 0;
    for (int i = 0; i < NWORDS; i++) mem[i] = '0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (rd) begin
        rd_cyc++;
        if (addr[12:11] != 2'b00 || int'({page_hi, addr[13]}) != cur_page) addr_bad++;
      end
      if (bus_grant) begin
        grant_cyc++;
        if (!grant_prev && (rd_cyc % (cur_ws + 1)) != 0) grant_bad++;
      end
      grant_prev = bus_grant;
      if (pm_we) begin
        mem[pm_addr] = pm_wdata;
        wr_cnt++;
      end
      if (done) begin
        done_cnt++;
        if (!(pm_we && pm_addr == 9'd511)) done_bad++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_done();
    int n = 0;
    while (done_cnt == 0 && n < 20000) begin
      @(posedge clk);
      n++;
    end
    chk(done_cnt != 0, "watchdog: done never seen", done_cnt, 1);
    repeat (2) @(posedge clk);
    #1;
  endtask

  task automatic verify(input string req, input int pg, input int ws);
    int bad = 0;
    for (int n = 0; n < NWORDS; n++)
      if (mem[n] != {rom_byte(3'(pg), 11'(3*n)), rom_byte(3'(pg), 11'(3*n+1)),
                     rom_byte(3'(pg), 11'(3*n+2))}) bad++;
    chk(rd_cyc == NBYTES * (ws + 1), {req, " R3 strobe cycles"}, rd_cyc, NBYTES * (ws + 1));
    chk(bad == 0, {req, " R4 word data"}, bad, 0);
    chk(wr_cnt == NWORDS, {req, " R4 word count"}, wr_cnt, NWORDS);
    chk(addr_bad == 0, {req, " R2 address/page pins"}, addr_bad, 0);
    chk(done_cnt == 1 && done_bad == 0, {req, " R7 done pulse"}, done_cnt, 1);
    chk(run == 1'b1, {req, " R7 run after boot"}, run, 1);
  endtask

  task automatic force_boot(input int pg, input int ws);
    @(posedge clk); #1;
    clear_counts();
    cur_page = pg; cur_ws = ws;
    cfg_we = 1'b1; cfg_force = 1'b1; cfg_page = 3'(pg); cfg_ws = 3'(ws);
    @(posedge clk); #1;
    cfg_we = 1'b0; cfg_force = 1'b0;
  endtask

  task automatic do_reset(input logic ms, input logic br);
    rst_n = 1'b0; map_sel = ms; bus_req = br;
    clear_counts();
    cur_page = 0; cur_ws = 3;
    repeat (3) @(posedge clk);
    #1;
    chk(!rd && !run && !done && !bus_grant, "R1 outputs in reset",
        int'({rd, run, done, bus_grant}), 0);
    rst_n = 1'b1;
  endtask

  // {page, wait states}
  localparam logic [5:0] VEC [5] = '{
    {3'd5, 3'd0}, {3'd2, 3'd7}, {3'd7, 3'd1}, {3'd1, 3'd3}, {3'd6, 3'd2}
  };

  initial begin
    #(200000 * 20);
    fails++;
    tests++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R1: automatic boot of page 0, default wait states
    do_reset(1'b0, 1'b0);
    wait_done();
    verify("R1 auto", 0, 3);

    // R8: forced boots across pages and wait settings
    foreach (VEC[i]) begin
      force_boot(int'(VEC[i][5:3]), int'(VEC[i][2:0]));
      wait_done();
      verify("R8 forced", int'(VEC[i][5:3]), int'(VEC[i][2:0]));
    end

    // R6: bus requests in mid-boot
    force_boot(3, 2);
    repeat (100) @(posedge clk);
    #1 bus_req = 1'b1;
    repeat (15) @(posedge clk);
    #1 bus_req = 1'b0;
    repeat (701) @(posedge clk);
    #1 bus_req = 1'b1;
    repeat (4) @(posedge clk);
    #1 bus_req = 1'b0;
    wait_done();
    verify("R6 bus request", 3, 2);
    chk(grant_cyc > 0, "R6 grant seen", grant_cyc, 1);
    chk(grant_bad == 0, "R6 grant at byte boundary", grant_bad, 0);

    // R9: control write during boot ignored
    force_boot(4, 1);
    repeat (50) @(posedge clk);
    #1 cfg_we = 1'b1; cfg_force = 1'b1; cfg_page = 3'd1; cfg_ws = 3'd6;
    @(posedge clk);
    #1 cfg_we = 1'b0; cfg_force = 1'b0;
    wait_done();
    verify("R9 write in boot", 4, 1);
    repeat (100) @(posedge clk);
    #1;
    chk(wr_cnt == NWORDS && rd_cyc == NBYTES * 2, "R9 no second boot", wr_cnt, NWORDS);

    // R10: bus request while running
    clear_counts();
    bus_req = 1'b1;
    repeat (5) @(posedge clk);
    #1;
    chk(grant_cyc == 0 && !bus_grant, "R10 no grant while running", grant_cyc, 0);
    chk(rd_cyc == 0 && run, "R10 no reads while running", rd_cyc, 0);
    bus_req = 1'b0;

    // R8: write without force starts nothing
    clear_counts();
    cfg_we = 1'b1; cfg_force = 1'b0; cfg_page = 3'd2; cfg_ws = 3'd5;
    @(posedge clk);
    #1 cfg_we = 1'b0;
    repeat (50) @(posedge clk);
    #1;
    chk(rd_cyc == 0 && wr_cnt == 0 && run, "R8 no boot without force", rd_cyc, 0);

    // R1: map select skips boot
    do_reset(1'b1, 1'b0);
    repeat (20) @(posedge clk);
    #1;
    chk(run == 1'b1, "R1 run with map select", run, 1);
    chk(rd_cyc == 0, "R1 no reads with map select", rd_cyc, 0);

    // R5: request pending at reset release
    do_reset(1'b0, 1'b1);
    repeat (20) @(posedge clk);
    #1;
    chk(bus_grant == 1'b1 && rd_cyc == 0, "R5 held off while requested", rd_cyc, 0);
    bus_req = 1'b0;
    wait_done();
    verify("R5 boot after release", 0, 3);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule